// File: doc/BRIEF.md
# Restart Vector and Interrupt Controller

This block keeps the processor-side interrupt state and turns both hardware requests and software restart commands into 16-bit restart vectors. It has one non-maskable request line and three maskable request levels, named by their vector position: level 5.5, level 6.5 and level 7.5. It also holds an interrupt-enable flip-flop, a mask bit for each maskable level, a halt state, and a status register that software can load and read.

The execution unit drives one command code per cycle. The codes are enable, disable, halt, write mask, software restart and read status. Whenever the block takes an interrupt or a software restart, it raises `take_o` for one cycle and updates `vector_o`. A hardware acceptance also clears the enable flip-flop, so the interrupt routine must re-enable interrupts explicitly. `halted_o` reports whether the processor is waiting in the halt state.

Software restart number n maps to the vector n×8. The hardware vectors sit 4 bytes above a software slot, which places them between the software slots.

Top module: `irqv_ctrl`

## Requirements
- R1: Command code 5 (software restart) with `cmd_arg` = n yields `take_o`=1 in the next cycle with `vector_o` = n×8 (0000h to 0038h), and the enable flip-flop is not changed.
- R2: The hardware vectors are 0024h for the non-maskable request, 003Ch for level 7.5, 0034h for level 6.5 and 002Ch for level 5.5.
- R3: A rising edge on `nmi_i` is latched at the clock edge that first sees it, and it is accepted at the following edge regardless of the enable flip-flop and the masks. Acceptance clears the latched request.
- R4: At most one request is accepted per cycle. The order is non-maskable first, then 7.5, then 6.5, then 5.5. A request that loses stays pending (7.5 and non-maskable) or is evaluated again while its level is held (6.5 and 5.5).
- R5: A maskable level is accepted only when the enable flip-flop is 1 and that level's mask bit is 0. Command 1 sets the flip-flop and command 2 clears it. Command 4 writes the mask from `cmd_arg`: bit0 masks 5.5, bit1 masks 6.5 and bit2 masks 7.5.
- R6: Synchronous reset clears the enable flip-flop, the pending requests, `halted_o`, `take_o`, `vector_o` and `status_o`, and sets all three mask bits. Every hardware acceptance also clears the enable flip-flop.
- R7: Command 3 (halt) sets `halted_o` in the next cycle. While the block is halted, every command is ignored. A hardware acceptance clears `halted_o` at the same edge that raises `take_o`. Reset also clears it.
- R8: Command 6 (read status) loads `status_o`. Bits 2:0 hold the mask, bit3 holds the enable flip-flop, bit4 and bit5 hold the 5.5 and 6.5 levels, bit6 holds the pending 7.5 request and bit7 is 0. All values are taken as they were before the edge. `status_o` holds its value until the next read-status command.
- R9: Level 7.5 is latched on a rising edge and stays pending while it is masked or disabled, until it is acknowledged. Levels 5.5 and 6.5 have no memory.
- R10: When a hardware request is accepted, a command presented in the same cycle has no effect. This includes enable and software restart.
- R11: `take_o` is high for exactly one cycle per accepted event, and `vector_o` holds the last vector between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Command: 0 none, 1 enable, 2 disable, 3 halt, 4 write mask, 5 software restart, 6 read status |
| cmd_arg | input | 3 | Mask value or restart number |
| nmi_i | input | 1 | Non-maskable request, edge-sensitive |
| lvl55_i | input | 1 | Level 5.5 request, level-sensitive |
| lvl65_i | input | 1 | Level 6.5 request, level-sensitive |
| edge75_i | input | 1 | Level 7.5 request, edge-sensitive |
| take_o | output | 1 | One-cycle strobe: vector valid |
| vector_o | output | 16 | Restart vector |
| halted_o | output | 1 | Halt state |
| status_o | output | 8 | Status register contents |

## Verification
A hardware acceptance can fall in the same cycle as a command, and the two most telling cases are an enable command and a software restart command. The bench forces both collisions on purpose. It holds level 5.5 high with interrupts enabled while it issues an enable command, and again while it issues a restart command. It then checks that only the hardware vector appears, and a later status read must show the enable bit as 0. Random traffic produces further collisions of this kind, and every cycle is compared with a bench model that gives acceptance precedence over any command.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int VW      = 16;
    localparam int SLOT_W  = 3;
    localparam int NLVL    = 3;
    localparam int STAT_W  = 8;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_EI    = 3'd1,
        CMD_DI    = 3'd2,
        CMD_HALT  = 3'd3,
        CMD_MASK  = 3'd4,
        CMD_SWRST = 3'd5,
        CMD_STAT  = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_L75  = 3'd2,
        SRC_L65  = 3'd3,
        SRC_L55  = 3'd4,
        SRC_SW   = 3'd5
    } src_e;

    typedef struct packed {
        logic nmi;
        logic l75;
        logic l65;
        logic l55;
    } grant_s;

    localparam logic [SLOT_W-1:0] SLOT_NMI = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_L55 = 3'd5;
    localparam logic [SLOT_W-1:0] SLOT_L65 = 3'd6;
    localparam logic [SLOT_W-1:0] SLOT_L75 = 3'd7;

    function automatic logic [VW-1:0] slot_vec(input logic [SLOT_W-1:0] n,
                                               input logic half);
        return {{(VW-SLOT_W-3){1'b0}}, n, half, 2'b00};
    endfunction
endpackage

// File: rtl/irqv_edge_latch.sv
module irqv_edge_latch #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic rise;
        assign rise = req[i] & ~req_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[i] <= 1'b0;
                pend[i]  <= 1'b0;
            end else begin
                req_q[i] <= req[i];
                pend[i]  <= rise | (pend[i] & ~clr[i]);
            end
        end

        // R9
        pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (pend[i] && !clr[i]) |=> pend[i])
            else $error("pending request lost without acknowledge");
    end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
    import irqv_pkg::*;
(
    input  logic            pend_nmi,
    input  logic            pend_l75,
    input  logic            lvl65,
    input  logic            lvl55,
    input  logic            ie,
    input  logic [NLVL-1:0] mask,
    output grant_s          grant,
    output src_e            src
);
    logic want75, want65, want55;

    assign want75 = ie & pend_l75 & ~mask[2];
    assign want65 = ie & lvl65    & ~mask[1];
    assign want55 = ie & lvl55    & ~mask[0];

    always_comb begin
        grant = '0;
        src   = SRC_NONE;
        if (pend_nmi) begin
            grant.nmi = 1'b1;
            src       = SRC_NMI;
        end else if (want75) begin
            grant.l75 = 1'b1;
            src       = SRC_L75;
        end else if (want65) begin
            grant.l65 = 1'b1;
            src       = SRC_L65;
        end else if (want55) begin
            grant.l55 = 1'b1;
            src       = SRC_L55;
        end
    end

    // R4
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant))
            else $error("more than one request granted");
    end
endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen
    import irqv_pkg::*;
(
    input  src_e              src,
    input  logic [SLOT_W-1:0] sw_num,
    output logic [VW-1:0]     vec
);
    always_comb begin
        unique case (src)
            SRC_NMI: vec = slot_vec(SLOT_NMI, 1'b1);
            SRC_L75: vec = slot_vec(SLOT_L75, 1'b1);
            SRC_L65: vec = slot_vec(SLOT_L65, 1'b1);
            SRC_L55: vec = slot_vec(SLOT_L55, 1'b1);
            SRC_SW:  vec = slot_vec(sw_num, 1'b0);
            default: vec = '0;
        endcase
    end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd_op,
    input  logic [SLOT_W-1:0] cmd_arg,
    input  logic              nmi_i,
    input  logic              lvl55_i,
    input  logic              lvl65_i,
    input  logic              edge75_i,
    output logic              take_o,
    output logic [VW-1:0]     vector_o,
    output logic              halted_o,
    output logic [STAT_W-1:0] status_o
);
    localparam logic [VW-1:0] V55 = slot_vec(SLOT_L55, 1'b1);

    logic              ie_q;
    logic [NLVL-1:0]   mask_q;
    logic              halted_q;
    logic              take_q;
    logic              hw_take_q;
    logic [VW-1:0]     vec_q;
    logic [STAT_W-1:0] stat_q;

    logic [1:0]        pend;
    grant_s            grant;
    src_e              hw_src;
    src_e              vsrc;
    logic              accept;
    logic [VW-1:0]     vec_next;
    cmd_e              cmd;

    assign cmd = cmd_e'(cmd_op);

    irqv_edge_latch #(.N(2)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .req  ({edge75_i, nmi_i}),
        .clr  ({grant.l75, grant.nmi}),
        .pend (pend)
    );

    irqv_arbiter u_arb (
        .pend_nmi (pend[0]),
        .pend_l75 (pend[1]),
        .lvl65    (lvl65_i),
        .lvl55    (lvl55_i),
        .ie       (ie_q),
        .mask     (mask_q),
        .grant    (grant),
        .src      (hw_src)
    );

    assign accept = (hw_src != SRC_NONE);
    assign vsrc   = accept ? hw_src : SRC_SW;

    irqv_vecgen u_vec (
        .src    (vsrc),
        .sw_num (cmd_arg),
        .vec    (vec_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q      <= 1'b0;
            mask_q    <= '1;
            halted_q  <= 1'b0;
            take_q    <= 1'b0;
            hw_take_q <= 1'b0;
            vec_q     <= '0;
            stat_q    <= '0;
        end else begin
            take_q    <= 1'b0;
            hw_take_q <= 1'b0;
            if (accept) begin
                take_q    <= 1'b1;
                hw_take_q <= 1'b1;
                vec_q     <= vec_next;
                ie_q      <= 1'b0;
                halted_q  <= 1'b0;
            end else if (!halted_q) begin
                unique case (cmd)
                    CMD_EI:    ie_q     <= 1'b1;
                    CMD_DI:    ie_q     <= 1'b0;
                    CMD_HALT:  halted_q <= 1'b1;
                    CMD_MASK:  mask_q   <= cmd_arg;
                    CMD_SWRST: begin
                        take_q <= 1'b1;
                        vec_q  <= vec_next;
                    end
                    CMD_STAT:  stat_q <= {1'b0, pend[1], lvl65_i, lvl55_i,
                                          ie_q, mask_q};
                    default:   ;
                endcase
            end
        end
    end

    assign take_o   = take_q;
    assign vector_o = vec_q;
    assign halted_o = halted_q;
    assign status_o = stat_q;

    // R6
    ack_clears_ie_chk: assert property (@(posedge clk) disable iff (rst)
        hw_take_q |-> !ie_q)
        else $error("enable survived an acknowledge");

    // R7
    halt_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(halted_q)) |-> hw_take_q)
        else $error("halt left without an accepted interrupt");

    // R2
    hw_vec_chk: assert property (@(posedge clk) disable iff (rst)
        hw_take_q |-> (take_q && vec_q[2:0] == 3'd4))
        else $error("hardware vector off its slot");

    // R1
    sw_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (take_q && !hw_take_q) |-> (vec_q[2:0] == 3'd0))
        else $error("software vector misaligned");

    // R5
    mask55_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_take_q && vec_q == V55) |-> $past(ie_q && !mask_q[0]))
        else $error("level 5.5 taken while blocked");
endmodule

// File: tb/tb_irqv_ctrl.sv
module tb_irqv_ctrl;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd_op = 3'd0;
    logic [2:0]  cmd_arg = 3'd0;
    logic        nmi_i = 1'b0, lvl55_i = 1'b0, lvl65_i = 1'b0, edge75_i = 1'b0;
    logic        take_o;
    logic [15:0] vector_o;
    logic        halted_o;
    logic [7:0]  status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_ie, m_halt, m_pn, m_p7, m_nq, m_eq, m_take;
    logic [2:0]  m_mask;
    logic [7:0]  m_stat;
    logic [15:0] m_vec;
    string       m_tag;

    always #(PERIOD/2) clk = ~clk;

    irqv_ctrl dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .nmi_i(nmi_i), .lvl55_i(lvl55_i), .lvl65_i(lvl65_i), .edge75_i(edge75_i),
        .take_o(take_o), .vector_o(vector_o), .halted_o(halted_o), .status_o(status_o)
    );

    function automatic logic [15:0] exp_vec(input int slot, input int half);
        return 16'(slot * 8 + half * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ie = 0; m_halt = 0; m_pn = 0; m_p7 = 0; m_nq = 0; m_eq = 0;
        m_take = 0; m_mask = 3'b111; m_stat = 0; m_vec = 0; m_tag = "R11";
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; cmd_op = 0; cmd_arg = 0;
        nmi_i = 0; lvl55_i = 0; lvl65_i = 0; edge75_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
        #1;
        chk("R6", {take_o, halted_o}, 2'b00);
        chk("R6", vector_o, 16'h0000);
        chk("R6", status_o, 8'h00);
    endtask

    task automatic step(input logic [2:0] op, input logic [2:0] arg,
                        input logic n, input logic l5, input logic l6, input logic e7);
        logic gn, g7, g6, g5, rn, r7;
        @(negedge clk);
        cmd_op = op; cmd_arg = arg;
        nmi_i = n; lvl55_i = l5; lvl65_i = l6; edge75_i = e7;
        gn = m_pn;
        g7 = !gn && m_ie && m_p7 && !m_mask[2];
        g6 = !gn && !g7 && m_ie && l6 && !m_mask[1];
        g5 = !gn && !g7 && !g6 && m_ie && l5 && !m_mask[0];
        rn = n & !m_nq;
        r7 = e7 & !m_eq;
        m_take = 0;
        m_tag = "R11";
        if (gn || g7 || g6 || g5) begin
            m_take = 1;
            m_vec = gn ? exp_vec(4, 1) : g7 ? exp_vec(7, 1) :
                    g6 ? exp_vec(6, 1) : exp_vec(5, 1);
            m_tag = gn ? "R3" : "R4";
            m_ie = 0;
            m_halt = 0;
        end else if (!m_halt) begin
            case (op)
                3'd1: m_ie = 1;
                3'd2: m_ie = 0;
                3'd3: m_halt = 1;
                3'd4: m_mask = arg;
                3'd5: begin m_take = 1; m_vec = exp_vec(int'(arg), 0); m_tag = "R1"; end
                3'd6: m_stat = {1'b0, m_p7, l6, l5, m_ie, m_mask};
                default: ;
            endcase
        end
        m_pn = rn | (m_pn & !gn);
        m_p7 = r7 | (m_p7 & !g7);
        m_nq = n;
        m_eq = e7;
        @(posedge clk);
        #1;
        chk(m_tag, take_o, m_take);
        chk(m_take ? (m_tag == "R1" ? "R1" : "R2") : "R11", vector_o, m_vec);
        chk("R7", halted_o, m_halt);
        chk("R8", status_o, m_stat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();

        // R6: reset mask all ones, enable clear
        step(3'd6, 0, 0, 0, 0, 0);
        chk("R6", status_o, 8'h07);

        // R1: every software restart slot
        for (int k = 0; k < 8; k++) begin
            step(3'd5, 3'(k), 0, 0, 0, 0);
            chk("R1", vector_o, exp_vec(k, 0));
        end
        // R11: strobe drops, vector held
        step(3'd0, 0, 0, 0, 0, 0);
        chk("R11", {31'd0, take_o}, 0);
        chk("R11", vector_o, 16'h0038);

        // R5: blocked while disabled
        step(3'd4, 3'b000, 0, 1, 0, 0);
        step(3'd0, 0, 0, 1, 0, 0);
        chk("R5", take_o, 0);
        step(3'd1, 0, 0, 1, 0, 0);
        step(3'd0, 0, 0, 1, 0, 0);
        chk("R2", vector_o, 16'h002C);
        step(3'd6, 0, 0, 0, 0, 0);
        chk("R6", status_o[3], 1'b0);

        // R10: enable and software restart lost against an acceptance
        step(3'd1, 0, 0, 0, 0, 0);
        step(3'd1, 0, 0, 1, 0, 0);
        chk("R10", vector_o, 16'h002C);
        step(3'd6, 0, 0, 0, 0, 0);
        chk("R10", status_o[3], 1'b0);
        step(3'd1, 0, 0, 0, 0, 0);
        step(3'd5, 3'd2, 0, 1, 0, 0);
        chk("R10", vector_o, 16'h002C);

        // R9: masked 7.5 stays pending
        step(3'd4, 3'b100, 0, 0, 0, 1);
        step(3'd1, 0, 0, 0, 0, 0);
        step(3'd6, 0, 0, 0, 0, 0);
        chk("R9", status_o[6], 1'b1);
        step(3'd4, 3'b000, 0, 0, 0, 0);
        step(3'd0, 0, 0, 0, 0, 0);
        chk("R9", vector_o, 16'h003C);

        // R4: all at once, NMI first then 7.5 then 6.5
        step(3'd1, 0, 0, 0, 0, 0);
        step(3'd0, 0, 1, 1, 1, 1);
        step(3'd0, 0, 1, 1, 1, 1);
        chk("R3", vector_o, 16'h0024);
        step(3'd1, 0, 1, 1, 1, 1);
        step(3'd0, 0, 1, 1, 1, 1);
        chk("R4", vector_o, 16'h003C);
        step(3'd1, 0, 0, 1, 1, 0);
        step(3'd0, 0, 0, 1, 1, 0);
        chk("R4", vector_o, 16'h0034);

        // R7: halt ignores commands, NMI wakes
        step(3'd3, 0, 0, 0, 0, 0);
        step(3'd1, 0, 0, 0, 0, 0);
        step(3'd5, 3'd1, 0, 1, 0, 0);
        chk("R7", {take_o, halted_o}, 2'b01);
        step(3'd0, 0, 1, 0, 0, 0);
        step(3'd0, 0, 1, 0, 0, 0);
        chk("R7", {take_o, halted_o}, 2'b10);
        chk("R3", vector_o, 16'h0024);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] op;
            r = int'($urandom % 20);
            op = (r < 7) ? 3'd0 : (r < 9) ? 3'd1 : (r < 10) ? 3'd2 :
                 (r < 11) ? 3'd3 : (r < 13) ? 3'd4 : (r < 16) ? 3'd5 : 3'd6;
            step(op, 3'($urandom), ($urandom % 16) == 0, $urandom % 4 == 0,
                 $urandom % 4 == 0, $urandom % 2 == 0);
            if (i % 1000 == 999) do_reset();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule